// File: doc/BRIEF.md
# Ring Oscillator Tuning Sequencer

This synchronous controller moves a ring oscillator's two tuning settings, a stage-count range level and a per-stage drive word, from their present values to a requested target. It never jumps. Each step changes the range by one level or flips one drive bit. After every step it waits for a settle tick before it takes the next one. The analog ring itself sits outside the block, which only produces the control values the ring consumes.

Raising the range level shortens the loop and cannot glitch the ring output, so consumers keep running through an upward walk. Lowering the level can glitch. Before each downward level change the block therefore asks consumers to move to an alternate clock and to hold reset. It changes the level only after an acknowledge arrives, and it withdraws the request once the next settle tick has been seen. The fastest level is unusable, so a request that targets it is refused and flagged.

Drive changes are placed on the safe side of the range walk. They are applied before an upward walk, while the ring is still at the slower level, and after a downward walk.

Top module: `rosc_tune_seq`

## Requirements
- R1: After reset, range_o is 0, drive_o is all zeros, and busy_o, err_o, alt_req_o and hold_rst_o are all low.
- R2: range_o uses the codes 0 (8 stages), 1 (6 stages), 2 (4 stages) and 3 (2 stages, forbidden). The block never outputs 3, and each range change moves the level by exactly one, in the direction of the target.
- R3: drive_o holds 3 bits per stage for 8 stages (stage s occupies bits 3s+2..3s). Each drive step flips exactly one bit, and it is always the lowest-index bit that still differs from the target.
- R4: After any range or drive step, no further step is taken until a settle tick has been sampled on a clock edge after the step edge.
- R5: If the target level is at or above the current level, every drive step comes before any range step. If the target level is below the current level, every range step comes before any drive step.
- R6: Before each downward range step, alt_req_o and hold_rst_o are high, and the level drops on the edge after alt_ack_i is sampled high while the request is up. Both outputs stay high until the first settle tick after the drop, and they are low in the cycle that follows that tick.
- R7: alt_req_o and hold_rst_o stay low during a move whose target level is not below the starting level.
- R8: A start request with target level 3 while the block is idle sets err_o, leaves busy_o low and leaves range_o and drive_o unchanged. err_o stays high until the next accepted start, which clears it.
- R9: busy_o goes high in the cycle after an accepted start and falls when the target is reached. A start_i pulse that arrives while busy_o is high is ignored.
- R10: When busy_o falls, range_o and drive_o equal the accepted target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start request, sampled only while idle |
| tgt_range_i | input | 2 | Requested range level |
| tgt_drive_i | input | 24 | Requested drive word |
| tick_i | input | 1 | Settle tick; one pulse releases the next step |
| alt_ack_i | input | 1 | Consumers have moved to the alternate clock |
| range_o | output | 2 | Live range level sent to the ring |
| drive_o | output | 24 | Live drive word sent to the ring |
| alt_req_o | output | 1 | Request to switch consumers to the alternate clock |
| hold_rst_o | output | 1 | Hold ring-clocked consumers in reset |
| busy_o | output | 1 | A move is in progress |
| err_o | output | 1 | Last start request targeted the forbidden level |

## Verification
Settle ticks and acknowledges arrive at random times, and every change of the outputs is compared, in order, against a step list the bench builds itself. A design that ignored the tick would show two steps with no tick between them. One that walked drive bits in the wrong order, or put drive steps on the wrong side of the range walk, would break the list. Downward walks check that each level drop is preceded by a request and an acknowledge, and that the request is released only after a tick; a design that dropped the level early, or dropped the request too soon, would hand consumers a glitching clock. The directed cases cover the forbidden level, a start while busy, a move with no change, and full 24-bit drive sweeps in both directions. A design that partly applied a refused target, or accepted a start while busy, would end at the wrong settings.

// File: rtl/rosc_tune_pkg.sv
package rosc_tune_pkg;
  localparam int RNG_W = 2;
  localparam logic [RNG_W-1:0] RNG_SLOWEST = 2'd0;
  localparam logic [RNG_W-1:0] RNG_FORBID  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE_DRV,
    S_UP,
    S_DN_REQ,
    S_DN_HOLD,
    S_POST_DRV
  } seq_e;

  function automatic logic level_ok(input logic [RNG_W-1:0] lvl);
    return lvl != RNG_FORBID;
  endfunction
endpackage

// File: rtl/rosc_drive_stepper.sv
module rosc_drive_stepper #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tgt_i,
  input  logic         step_i,
  output logic [W-1:0] drive_o,
  output logic         done_o
);
  logic [W-1:0] drive_q;
  logic [W-1:0] flip_w;

  // isolate the lowest set bit of a difference vector
  function automatic logic [W-1:0] lowest_one(input logic [W-1:0] v);
    return v & (~v + {{(W-1){1'b0}}, 1'b1});
  endfunction

  assign flip_w  = lowest_one(drive_q ^ tgt_i);
  assign done_o  = (drive_q == tgt_i);
  assign drive_o = drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= '0;
    else if (step_i) drive_q <= drive_q ^ flip_w;
  end

  p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> $countones(drive_o ^ $past(drive_o)) == 1);
  p_hold_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(drive_o));
endmodule

// File: rtl/rosc_range_reg.sv
module rosc_range_reg
  import rosc_tune_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [RNG_W-1:0] range_o
);
  logic [RNG_W-1:0] lvl_q;

  function automatic logic [RNG_W-1:0] next_level(input logic [RNG_W-1:0] cur,
                                                  input logic up, input logic dn);
    if (up) return cur + 1'b1;
    if (dn) return cur - 1'b1;
    return cur;
  endfunction

  assign range_o = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= RNG_SLOWEST;
    else lvl_q <= next_level(lvl_q, up_i, dn_i);
  end

  p_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_i && dn_i));
  p_never_forbid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    range_o != RNG_FORBID);
endmodule

// File: rtl/rosc_tune_seq.sv
module rosc_tune_seq
  import rosc_tune_pkg::*;
#(
  parameter int N_STAGES   = 8,
  parameter int BITS_STAGE = 3,
  localparam int DW        = N_STAGES * BITS_STAGE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    tgt_range_i,
  input  logic [DW-1:0] tgt_drive_i,
  input  logic          tick_i,
  input  logic          alt_ack_i,
  output logic [1:0]    range_o,
  output logic [DW-1:0] drive_o,
  output logic          alt_req_o,
  output logic          hold_rst_o,
  output logic          busy_o,
  output logic          err_o
);
  seq_e          st_q;
  logic          settle_q;
  logic          req_q;
  logic          err_q;
  logic [1:0]    tgt_rng_q;
  logic [DW-1:0] tgt_drv_q;

  // named internal events
  logic drv_step, drv_done, rng_up, rng_dn, start_ok, start_bad, any_step;

  assign start_ok  = (st_q == S_IDLE) && start_i && level_ok(tgt_range_i);
  assign start_bad = (st_q == S_IDLE) && start_i && !level_ok(tgt_range_i);
  assign drv_step  = !settle_q && !drv_done &&
                     ((st_q == S_PRE_DRV) || (st_q == S_POST_DRV));
  assign rng_up    = !settle_q && (st_q == S_UP) && (range_o < tgt_rng_q);
  assign rng_dn    = (st_q == S_DN_REQ) && req_q && alt_ack_i &&
                     (range_o > tgt_rng_q);
  assign any_step  = drv_step || rng_up || rng_dn;

  rosc_drive_stepper #(.W(DW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_i  (tgt_drv_q),
    .step_i (drv_step),
    .drive_o(drive_o),
    .done_o (drv_done)
  );

  rosc_range_reg u_range (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (rng_up),
    .dn_i   (rng_dn),
    .range_o(range_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      settle_q  <= 1'b0;
      req_q     <= 1'b0;
      err_q     <= 1'b0;
      tgt_rng_q <= RNG_SLOWEST;
      tgt_drv_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_ok) begin
            err_q     <= 1'b0;
            settle_q  <= 1'b0;
            tgt_rng_q <= tgt_range_i;
            tgt_drv_q <= tgt_drive_i;
            st_q      <= (tgt_range_i < range_o) ? S_DN_REQ : S_PRE_DRV;
          end else if (start_bad) begin
            err_q <= 1'b1;
          end
        end
        S_PRE_DRV, S_POST_DRV: begin
          if (settle_q) begin
            if (tick_i) settle_q <= 1'b0;
          end else if (drv_done) begin
            st_q <= (st_q == S_PRE_DRV) ? S_UP : S_IDLE;
          end else begin
            settle_q <= 1'b1;
          end
        end
        S_UP: begin
          if (settle_q) begin
            if (tick_i) settle_q <= 1'b0;
          end else if (rng_up) begin
            settle_q <= 1'b1;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_DN_REQ: begin
          if (range_o == tgt_rng_q) st_q <= S_POST_DRV;
          else if (!req_q) req_q <= 1'b1;
          else if (rng_dn) st_q <= S_DN_HOLD;
        end
        S_DN_HOLD: begin
          if (tick_i) begin
            req_q <= 1'b0;
            st_q  <= S_DN_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign alt_req_o  = req_q;
  assign hold_rst_o = req_q;
  assign busy_o     = (st_q != S_IDLE);
  assign err_o      = err_q;

  p_step_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |=> !any_step);
  p_dn_keeps_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rng_dn |=> (alt_req_o && hold_rst_o));
  p_up_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rng_up |-> !alt_req_o);
  p_bad_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (err_o && !busy_o && $stable(range_o) && $stable(drive_o)));
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(tgt_rng_q) && $stable(tgt_drv_q)));
  p_done_at_tgt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (range_o == tgt_rng_q && drive_o == tgt_drv_q));
endmodule

// File: tb/rosc_tune_seq_bench.sv
module rosc_tune_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  tgt_range_i;
  logic [23:0] tgt_drive_i;
  logic        tick_i;
  logic        alt_ack_i;
  logic [1:0]  range_o;
  logic [23:0] drive_o;
  logic        alt_req_o, hold_rst_o, busy_o, err_o;

  int checks = 0;
  int errors = 0;
  logic [1:0]  er[64];
  logic [23:0] ed[64];
  int n_exp;

  always #4 clk = ~clk;

  rosc_tune_seq u_rosc_tune_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_range_i(tgt_range_i),
    .tgt_drive_i(tgt_drive_i), .tick_i(tick_i), .alt_ack_i(alt_ack_i),
    .range_o(range_o), .drive_o(drive_o), .alt_req_o(alt_req_o),
    .hold_rst_o(hold_rst_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // index of the first differing bit, found by scanning upward
  function automatic int first_diff(input logic [23:0] a, input logic [23:0] b);
    for (int i = 0; i < 24; i++) if (a[i] != b[i]) return i;
    return -1;
  endfunction

  task automatic plan(input logic [1:0] r0, input logic [23:0] d0,
                      input logic [1:0] tr, input logic [23:0] td);
    logic [1:0] r;
    logic [23:0] d;
    r = r0; d = d0; n_exp = 0;
    if (tr < r) begin
      while (r > tr) begin r = r - 2'd1; er[n_exp] = r; ed[n_exp] = d; n_exp++; end
      while (d != td) begin
        d[first_diff(d, td)] ^= 1'b1; er[n_exp] = r; ed[n_exp] = d; n_exp++;
      end
    end else begin
      while (d != td) begin
        d[first_diff(d, td)] ^= 1'b1; er[n_exp] = r; ed[n_exp] = d; n_exp++;
      end
      while (r < tr) begin r = r + 2'd1; er[n_exp] = r; ed[n_exp] = d; n_exp++; end
    end
  endtask

  task automatic run_move(input logic [1:0] tr, input logic [23:0] td, input bit poke);
    bit down, need_tick, dn_pend, saw_req, p_tick, p_ack, p_req, p_hold;
    logic [1:0] pr;
    logic [23:0] pd;
    int k, cyc;
    plan(range_o, drive_o, tr, td);
    down = (tr < range_o);
    @(negedge clk);
    start_i = 1'b1; tgt_range_i = tr; tgt_drive_i = td;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
    chk(err_o == 1'b0, "R8", "err cleared by legal start", err_o, 0);
    k = 0; cyc = 0; need_tick = 0; dn_pend = 0; saw_req = 0;
    pr = range_o; pd = drive_o;
    while (busy_o && cyc < 4000) begin
      tick_i    = ($urandom % 3) == 0;
      alt_ack_i = alt_req_o && (($urandom % 2) == 0);
      if (poke && cyc == 5) begin
        start_i = 1'b1; tgt_range_i = 2'd0; tgt_drive_i = ~td;
      end
      p_tick = tick_i; p_ack = alt_ack_i; p_req = alt_req_o; p_hold = hold_rst_o;
      @(negedge clk);
      start_i = 1'b0; cyc++;
      if (range_o != pr || drive_o != pd) begin
        if (k < n_exp) begin
          chk(range_o == er[k], "R2", "range at step", range_o, er[k]);
          chk(drive_o == ed[k], "R3", "drive at step (R5 order)", drive_o, ed[k]);
        end else chk(0, "R5", "extra step", k, n_exp);
        chk(!need_tick, "R4", "step without settle tick", k, 0);
        if (range_o < pr) begin
          chk(p_req && p_hold && p_ack, "R6", "drop without req/ack",
              {p_req, p_hold, p_ack}, 3'b111);
          chk(alt_req_o && hold_rst_o, "R6", "req held after drop", alt_req_o, 1);
          dn_pend = 1;
        end
        k++; need_tick = 1;
      end else if (p_tick) begin
        need_tick = 0;
        if (dn_pend) begin
          chk(!alt_req_o && !hold_rst_o, "R6", "req release after tick", alt_req_o, 0);
          dn_pend = 0;
        end
      end
      if (!down && (alt_req_o || hold_rst_o)) saw_req = 1;
      pr = range_o; pd = drive_o;
    end
    tick_i = 1'b0; alt_ack_i = 1'b0;
    chk(cyc < 4000, "R9", "move timed out", cyc, 4000);
    chk(k == n_exp, "R5", "step count", k, n_exp);
    chk(range_o == tr, "R10", "final range", range_o, tr);
    chk(drive_o == td, "R10", "final drive", drive_o, td);
    chk(!alt_req_o && !hold_rst_o, "R6", "req low at end", alt_req_o, 0);
    if (!down) chk(!saw_req, "R7", "req during upward move", saw_req, 0);
  endtask

  task automatic bad_start();
    logic [1:0] r0;
    logic [23:0] d0;
    r0 = range_o; d0 = drive_o;
    @(negedge clk);
    start_i = 1'b1; tgt_range_i = 2'd3; tgt_drive_i = ~d0;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8", "err after forbidden level", err_o, 1);
    chk(busy_o == 1'b0, "R8", "busy after forbidden level", busy_o, 0);
    for (int i = 0; i < 6; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
    chk(range_o == r0, "R8", "range untouched", range_o, r0);
    chk(drive_o == d0, "R8", "drive untouched", drive_o, d0);
    chk(err_o == 1'b1, "R8", "err stays", err_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; tgt_range_i = '0; tgt_drive_i = '0;
    tick_i = 1'b0; alt_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(range_o == 2'd0 && drive_o == 24'h0, "R1", "reset settings", {range_o, drive_o}, 0);
    chk(!busy_o && !err_o && !alt_req_o && !hold_rst_o, "R1", "reset flags",
        {busy_o, err_o, alt_req_o, hold_rst_o}, 0);
    run_move(2'd2, 24'hFFFFFF, 1'b0);  // full upward sweep
    run_move(2'd0, 24'h000000, 1'b0);  // full downward sweep
    run_move(2'd0, 24'h000000, 1'b0);  // no change at all
    run_move(2'd0, 24'h800001, 1'b0);  // drive only, end bits
    run_move(2'd2, 24'h5A5A5A, 1'b1);  // start while busy ignored (R9)
    bad_start();
    run_move(2'd1, 24'h00F00F, 1'b0);  // downward by one, clears err
    for (int j = 0; j < 20; j++) begin
      if (j == 10) bad_start();
      run_move(2'($urandom % 3), 24'($urandom), (j % 4) == 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule